// File: doc/BRIEF.md
# Audio sample buffer error tracker

This block sits between a host that moves audio samples and a converter that runs on its own sample clock. It holds one outgoing playback sample and one incoming capture sample. On each converter sample tick it hands the held playback sample to the DAC and takes a new sample from the ADC. It also detects when either side has fallen behind.

If the host has not supplied a fresh playback sample before a tick, that is an underrun. The DAC then receives either the last valid sample again or silence, as a control input selects. If the host has not collected the previous capture sample before the next one arrives, that is an overrun. The unread sample is kept and the new one is dropped. Both errors set flags that stay set until the host reads the status register. A summary bit reports whether either flag is set.

Top module: `audio_buf_err_trk`

## Requirements
- R1: A `host_wr` stores `host_wr_data` and marks the playback slot full. A `smp_tick` that sees the slot full drives that sample on `dac_data` from the next cycle on and empties the slot.
- R2: A `smp_tick` that sees the playback slot empty raises `under_flag` from the next cycle on.
- R3: On an underrun with `zero_on_under` = 0, `dac_data` takes the last sample the host wrote (zero if none since reset).
- R4: On an underrun with `zero_on_under` = 1, `dac_data` becomes all zeros.
- R5: A `smp_tick` that finds the capture slot empty stores `adc_data`. From the next cycle, `cap_data` shows it and `cap_full` = 1.
- R6: A `smp_tick` that finds the capture slot full, with no `host_rd` in that cycle, raises `over_flag`, leaves `cap_data` unchanged and drops the new sample.
- R7: A `host_rd` clears `cap_full`. A `host_rd` and a `smp_tick` in the same cycle accept the new sample with no overrun.
- R8: Both flags stay set until a cycle with `stat_rd` = 1. That cycle clears them if no new event of the same kind occurs in it.
- R9: An underrun or overrun in the same cycle as `stat_rd` leaves the corresponding flag set.
- R10: `err_any` equals the OR of `under_flag` and `over_flag` in every cycle.
- R11: Synchronous reset drives all outputs to zero and empties both slots.
- R12: A `host_wr` in the same cycle as a `smp_tick` with the playback slot empty does not prevent the underrun. The written sample is held for the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host writes a playback sample |
| host_wr_data | input | SAMPLE_W | Playback sample from host |
| host_rd | input | 1 | Host consumes the capture sample |
| smp_tick | input | 1 | Converter sample tick |
| adc_data | input | SAMPLE_W | Incoming capture sample |
| zero_on_under | input | 1 | 1: send zero on underrun, 0: repeat last sample |
| stat_rd | input | 1 | Host reads the status register |
| dac_data | output | SAMPLE_W | Sample sent to the DAC |
| cap_data | output | SAMPLE_W | Held capture sample for the host |
| cap_full | output | 1 | Capture slot holds an unread sample |
| under_flag | output | 1 | Sticky playback underrun flag |
| over_flag | output | 1 | Sticky capture overrun flag |
| err_any | output | 1 | OR of both error flags |

## Verification
The hardest cases to reach are coincidences within one cycle. One is a status read that lands on the same edge as a fresh error. Another is a host read or write that meets the sample tick. Directed sequences force each of these collisions on purpose. A long seeded random run with dense ticks and sparse host traffic then produces many more of them, and every cycle is compared with a cycle-level bench model.

// File: rtl/audbuf_pkg.sv
package audbuf_pkg;
  typedef struct packed {
    logic under;
    logic over;
  } err_ev_t;
endpackage

// File: rtl/abuf_play_slot.sv
module abuf_play_slot #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                tick,
  input  logic                zero_mode,
  output logic [SAMPLE_W-1:0] dac,
  output logic                ev_under
);
  localparam logic [SAMPLE_W-1:0] SILENCE = '0;

  logic [SAMPLE_W-1:0] hold_q;
  logic                full_q;

  assign ev_under = tick && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
      dac    <= '0;
    end else begin
      if (tick) begin
        if (full_q)         dac <= hold_q;
        else if (zero_mode) dac <= SILENCE;
        else                dac <= hold_q;
      end
      if (wr) begin
        hold_q <= wr_data;
        full_q <= 1'b1;
      end else if (tick) begin
        full_q <= 1'b0;
      end
    end
  end

  // R4: silence on underrun when selected
  a_r4_zero_on_under: assert property (@(posedge clk) disable iff (rst)
    tick && !full_q && zero_mode |=> dac == SILENCE);
  // R3: repeat last written sample on underrun
  a_r3_repeat_last: assert property (@(posedge clk) disable iff (rst)
    tick && !full_q && !zero_mode |=> dac == $past(hold_q));
  // R1: a consumed sample empties the slot unless refilled
  a_r1_tick_empties: assert property (@(posedge clk) disable iff (rst)
    tick && !wr |=> !full_q);
endmodule

// File: rtl/abuf_cap_slot.sv
module abuf_cap_slot #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [SAMPLE_W-1:0] adc,
  input  logic                rd,
  output logic [SAMPLE_W-1:0] cap,
  output logic                full,
  output logic                ev_over
);
  logic slot_free;

  assign slot_free = !full || rd;
  assign ev_over   = tick && !slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap  <= '0;
      full <= 1'b0;
    end else if (tick && slot_free) begin
      cap  <= adc;
      full <= 1'b1;
    end else if (rd) begin
      full <= 1'b0;
    end
  end

  // R6: an unread sample is never overwritten
  a_r6_keep_old: assert property (@(posedge clk) disable iff (rst)
    full && !rd |=> $stable(cap));
  // R5: accepted sample fills the slot
  a_r5_fill: assert property (@(posedge clk) disable iff (rst)
    tick && !full |=> full && cap == $past(adc));
  // R7: read without tick empties the slot
  a_r7_read_empties: assert property (@(posedge clk) disable iff (rst)
    rd && !tick |=> !full);
endmodule

// File: rtl/abuf_err_flags.sv
module abuf_err_flags
  import audbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  err_ev_t ev,
  input  logic    stat_rd,
  output logic    under_flag,
  output logic    over_flag,
  output logic    err_any
);
  logic under_nxt, over_nxt;

  assign under_nxt = ev.under || (under_flag && !stat_rd);
  assign over_nxt  = ev.over  || (over_flag  && !stat_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      under_flag <= 1'b0;
      over_flag  <= 1'b0;
      err_any    <= 1'b0;
    end else begin
      under_flag <= under_nxt;
      over_flag  <= over_nxt;
      err_any    <= under_nxt || over_nxt;
    end
  end

  // R9: an event is never lost, even beside a status read
  a_r9_under_kept: assert property (@(posedge clk) disable iff (rst)
    ev.under |=> under_flag);
  a_r9_over_kept: assert property (@(posedge clk) disable iff (rst)
    ev.over |=> over_flag);
  // R8: flags are sticky without a status read
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (under_flag || over_flag) && !stat_rd |=> err_any);
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !ev.under && !ev.over |=> !err_any);
  // R10: summary bit tracks both flags
  a_r10_summary: assert property (@(posedge clk) disable iff (rst)
    err_any == (under_flag || over_flag));
endmodule

// File: rtl/audio_buf_err_trk.sv
module audio_buf_err_trk
  import audbuf_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic [SAMPLE_W-1:0] host_wr_data,
  input  logic                host_rd,
  input  logic                smp_tick,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                zero_on_under,
  input  logic                stat_rd,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic [SAMPLE_W-1:0] cap_data,
  output logic                cap_full,
  output logic                under_flag,
  output logic                over_flag,
  output logic                err_any
);
  err_ev_t ev;

  abuf_play_slot #(.SAMPLE_W(SAMPLE_W)) u_play (
    .clk(clk), .rst(rst), .wr(host_wr), .wr_data(host_wr_data),
    .tick(smp_tick), .zero_mode(zero_on_under), .dac(dac_data),
    .ev_under(ev.under)
  );

  abuf_cap_slot #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk), .rst(rst), .tick(smp_tick), .adc(adc_data), .rd(host_rd),
    .cap(cap_data), .full(cap_full), .ev_over(ev.over)
  );

  abuf_err_flags u_flags (
    .clk(clk), .rst(rst), .ev(ev), .stat_rd(stat_rd),
    .under_flag(under_flag), .over_flag(over_flag), .err_any(err_any)
  );

  // R11: outputs cleared the cycle after reset
  a_r11_reset: assert property (@(posedge clk)
    rst |=> dac_data == '0 && !cap_full && !err_any);
  // R2: tick with empty slot is reported
  a_r2_under: assert property (@(posedge clk) disable iff (rst)
    ev.under |=> under_flag && err_any);
endmodule

// File: tb/audio_buf_err_trk_tb.sv
`timescale 1ns/1ps
module audio_buf_err_trk_tb;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, host_rd = 0, smp_tick = 0, zero_on_under = 0, stat_rd = 0;
  logic [W-1:0] host_wr_data = '0, adc_data = '0;
  logic [W-1:0] dac_data, cap_data;
  logic cap_full, under_flag, over_flag, err_any;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_hold = '0, m_dac = '0, m_cap = '0;
  logic m_pfull = 0, m_cfull = 0, m_under = 0, m_over = 0;

  always #2 clk = ~clk;

  audio_buf_err_trk #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wr_data(host_wr_data),
    .host_rd(host_rd), .smp_tick(smp_tick), .adc_data(adc_data),
    .zero_on_under(zero_on_under), .stat_rd(stat_rd), .dac_data(dac_data),
    .cap_data(cap_data), .cap_full(cap_full), .under_flag(under_flag),
    .over_flag(over_flag), .err_any(err_any)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] dac_after_tick(logic full, logic zmode,
                                                 logic [W-1:0] hold);
    if (full) return hold;          // R1
    return zmode ? '0 : hold;       // R4 / R3
  endfunction

  task automatic model_edge();
    logic ev_u, ev_o, free;
    ev_u = smp_tick && !m_pfull;
    free = !m_cfull || host_rd;
    ev_o = smp_tick && !free;
    if (smp_tick) m_dac = dac_after_tick(m_pfull, zero_on_under, m_hold);
    if (host_wr) begin m_hold = host_wr_data; m_pfull = 1; end
    else if (smp_tick) m_pfull = 0;
    if (smp_tick && free) begin m_cap = adc_data; m_cfull = 1; end
    else if (host_rd) m_cfull = 0;
    m_under = ev_u || (m_under && !stat_rd);
    m_over  = ev_o || (m_over && !stat_rd);
  endtask

  task automatic compare_all();
    check("R1/R3/R4 dac_data", 32'(dac_data), 32'(m_dac));
    check("R5/R6 cap_data", 32'(cap_data), 32'(m_cap));
    check("R7 cap_full", 32'(cap_full), 32'(m_cfull));
    check("R2/R8/R9 under_flag", 32'(under_flag), 32'(m_under));
    check("R6/R8/R9 over_flag", 32'(over_flag), 32'(m_over));
    check("R10 err_any", 32'(err_any), 32'(m_under || m_over));
  endtask

  // drive at negedge, edge, check at next negedge
  task automatic cyc(logic wr, logic [W-1:0] wd, logic rd, logic tk,
                     logic [W-1:0] ad, logic zm, logic sr);
    host_wr = wr; host_wr_data = wd; host_rd = rd; smp_tick = tk;
    adc_data = ad; zero_on_under = zm; stat_rd = sr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    host_wr = 0; host_rd = 0; smp_tick = 0; stat_rd = 0;
    compare_all();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    check("R11 dac_data", 32'(dac_data), 0);
    check("R11 cap_full", 32'(cap_full), 0);
    check("R11 err_any", 32'(err_any), 0);
    // R1 write then tick
    cyc(1, 16'hA1A1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 16'h0C01, 0, 0);
    check("R1 dac=written", 32'(dac_data), 32'hA1A1);
    check("R5 cap stored", 32'(cap_data), 32'h0C01);
    // R2 R3 underrun repeats
    cyc(0, 0, 1, 1, 16'h0C02, 0, 0);
    check("R2 under_flag", 32'(under_flag), 1);
    check("R3 repeat last", 32'(dac_data), 32'hA1A1);
    check("R7 read+tick no overrun", 32'(over_flag), 0);
    check("R7 new sample accepted", 32'(cap_data), 32'h0C02);
    // R6 overrun
    cyc(0, 0, 0, 1, 16'h0C03, 0, 0);
    check("R6 over_flag", 32'(over_flag), 1);
    check("R6 old kept", 32'(cap_data), 32'h0C02);
    // R8 status read clears
    cyc(0, 0, 0, 0, 0, 0, 1);
    check("R8 cleared", 32'(err_any), 0);
    // R4 zero on underrun, and R9 event beside status read
    cyc(0, 0, 0, 1, 16'h0C04, 1, 1);
    check("R4 zero dac", 32'(dac_data), 0);
    check("R9 under kept", 32'(under_flag), 1);
    check("R9 over kept", 32'(over_flag), 1);
    // R12 write with tick on empty slot
    cyc(1, 16'hB2B2, 1, 1, 16'h0C05, 0, 1);
    check("R12 underrun despite write", 32'(under_flag), 1);
    check("R12 dac repeats old", 32'(dac_data), 32'hA1A1);
    cyc(0, 0, 0, 1, 16'h0C06, 0, 0);
    check("R12 held sample sent", 32'(dac_data), 32'hB2B2);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 5) == 0, W'($urandom), ($urandom % 4) == 0,
          ($urandom % 3) == 0, W'($urandom), ($urandom % 2) == 0,
          ($urandom % 8) == 0);
    end
    // R11: reset mid-run
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    m_hold = '0; m_dac = '0; m_cap = '0;
    m_pfull = 0; m_cfull = 0; m_under = 0; m_over = 0;
    compare_all();
    cyc(0, 0, 0, 1, 16'h0D01, 0, 0);
    check("R11 R3 repeat after reset is zero", 32'(dac_data), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule